// File: doc/BRIEF.md
# Table-Driven Phase Bisection Estimator

This block recovers the phase of a rectified, roughly sinusoidal intensity profile whose spatial frequency is already known. A profile of `NPIX` corrected pixel intensities streams in after a start pulse. While it arrives, the block correlates the samples with two stored per-pixel tables, one of sines and one of cosines of the known spatial frequency. This yields a sine sum and a cosine sum.

Once the last pixel is in, the block searches a grid of `NODES` phase nodes spread evenly over [−π, π). It uses a fixed-length binary search. At each probe it evaluates an optimality value built only from the two sums and three per-node tables: the node's sine, the node's cosine and an additive correction term. No arctangent and no iterative fit is used. A final comparison between the two surviving neighbouring nodes picks the one with the smaller magnitude. The chosen node index is presented with a one-cycle done strobe, a fixed number of cycles after the last pixel.

All five tables are loaded from outside through a single write port before profiles are processed. Node k stands for the phase −π + 2πk/NODES.

Top module: `phase_bisect_est`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `done_o` is 0 and `phase_o` is 0.
- R2: A write with `tab_we`=1 stores `tab_wdata` at `tab_addr` in the table selected by `tab_sel`: 0 pixel sine, 1 pixel cosine, 2 node sine, 3 node cosine, 4 node correction. Pixel-table writes with `tab_addr` ≥ NPIX are dropped.
- R3: A profile is started by `start_i` only while the block is idle. The next NPIX cycles with `pix_vld`=1 supply pixels 0..NPIX−1, and gaps are allowed. Pixels while idle, and `start_i` or pixels during a search, have no effect on any result.
- R4: The sine sum Ss = Σ pix[i]·psin[i] and the cosine sum Sc = Σ pix[i]·pcos[i] are formed at full precision with all values signed. Each sum is then reduced to SUM_W=18 bits by an arithmetic right shift of (PIX_W+TAB_W+⌈log2 NPIX⌉−SUM_W) bits.
- R5: The optimality value of node k is F(k) = (ncor[k] << CORR_SH) − nsin[k]·Sc − ncos[k]·Ss, with CORR_SH=8 by default.
- R6: The search starts with lo=0 and step=NODES/2. Each probe evaluates mid=lo+step, sets lo=mid when F(mid)>0, and then halves step. There are log2(NODES) probes.
- R7: After the probes, the result is node (lo+1) mod NODES if |F| there is strictly smaller than |F(lo)|. Otherwise the result is lo.
- R8: `done_o` is high for exactly one cycle, 3·log2(NODES)+7 clock edges after the edge that takes the last pixel. `phase_o` changes only together with `done_o` and holds its value between strobes.
- R9: Suppose the pixel tables hold round(16384·sin/cos(2πf·i)) and the node tables hold round(16384·sin/cos θk) with zero correction. Suppose also that NPIX·2f is an integer. Then for a clean profile A·cos(2πf·i+θ) the returned node is within one node, measured around the circle, of the true phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tab_we | input | 1 | Table write enable |
| tab_sel | input | 3 | Table select code (see R2) |
| tab_addr | input | log2(NODES) | Table write address |
| tab_wdata | input | TAB_W | Table write data, signed |
| start_i | input | 1 | Start of a profile |
| pix_vld | input | 1 | Pixel valid |
| pix_dat | input | PIX_W | Corrected pixel intensity, signed |
| done_o | output | 1 | One-cycle result strobe |
| phase_o | output | log2(NODES) | Chosen phase node index |

## Verification
The bench builds the block with its defaults: NPIX=20, NODES=1024, 16-bit pixels and table entries, and 18-bit sums. Ten probes therefore run, which brings the full-depth search within reach, along with the wrap of the final neighbour from node 1023 back to node 0. The 20-pixel profile with spatial frequency 0.2 makes the double-frequency sums vanish, so clean cosines must land within one node of their true phase, including phases at the ±π seam. Tables filled with random full-range values expose the exact reduction, sign rule and final comparison against a bench model.

// File: rtl/phs_pkg.sv
package phs_pkg;
  typedef enum logic [2:0] {S_IDLE, S_ACC, S_FLUSH, S_RD, S_MUL, S_EVAL} st_e;
  typedef enum logic [1:0] {P_BIS, P_LO, P_HI} pass_e;
  localparam logic [2:0] SEL_PSIN = 3'd0;
  localparam logic [2:0] SEL_PCOS = 3'd1;
  localparam logic [2:0] SEL_NSIN = 3'd2;
  localparam logic [2:0] SEL_NCOS = 3'd3;
  localparam logic [2:0] SEL_NCOR = 3'd4;
endpackage

// File: rtl/phs_ram.sv
module phs_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/phs_corr.sv
module phs_corr #(
  parameter int NPIX  = 20,
  parameter int PIX_W = 16,
  parameter int TAB_W = 16,
  parameter int SUM_W = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    take,
  input  logic signed [PIX_W-1:0] pix,
  input  logic signed [TAB_W-1:0] t_sin,
  input  logic signed [TAB_W-1:0] t_cos,
  output logic signed [SUM_W-1:0] sum_s,
  output logic signed [SUM_W-1:0] sum_c
);
  localparam int PW    = PIX_W + TAB_W;
  localparam int ACC_W = PW + $clog2(NPIX);

  logic signed [PIX_W-1:0] p_q;
  logic                    v_q;
  logic signed [PW-1:0]    pr_s, pr_c;
  logic signed [ACC_W-1:0] acc_s, acc_c;

  assign pr_s = PW'(p_q) * PW'(t_sin);
  assign pr_c = PW'(p_q) * PW'(t_cos);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= 1'b0;
      p_q   <= '0;
      acc_s <= '0;
      acc_c <= '0;
    end else begin
      v_q <= take;
      if (take) p_q <= pix;
      if (clr) begin
        acc_s <= '0;
        acc_c <= '0;
      end else if (v_q) begin
        acc_s <= acc_s + ACC_W'(pr_s);
        acc_c <= acc_c + ACC_W'(pr_c);
      end
    end
  end

  // Arithmetic right shift by ACC_W-SUM_W: keep the top bits (R4)
  assign sum_s = acc_s[ACC_W-1 -: SUM_W];
  assign sum_c = acc_c[ACC_W-1 -: SUM_W];

  // R4
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_s == '0) && (acc_c == '0));
endmodule

// File: rtl/phs_obj.sv
module phs_obj #(
  parameter int SUM_W   = 18,
  parameter int TAB_W   = 16,
  parameter int CORR_SH = 8,
  parameter int F_W     = 36
) (
  input  logic                    clk,
  input  logic signed [SUM_W-1:0] sum_s,
  input  logic signed [SUM_W-1:0] sum_c,
  input  logic signed [TAB_W-1:0] n_sin,
  input  logic signed [TAB_W-1:0] n_cos,
  input  logic signed [TAB_W-1:0] n_cor,
  output logic signed [F_W-1:0]   f
);
  localparam int MW = SUM_W + TAB_W;

  logic signed [MW-1:0]    m_a, m_b;
  logic signed [TAB_W-1:0] c_q;

  always_ff @(posedge clk) begin
    m_a <= MW'(n_sin) * MW'(sum_c);
    m_b <= MW'(n_cos) * MW'(sum_s);
    c_q <= n_cor;
  end

  assign f = (F_W'(c_q) <<< CORR_SH) - F_W'(m_a) - F_W'(m_b);
endmodule

// File: rtl/phase_bisect_est.sv
module phase_bisect_est #(
  parameter int  NPIX    = 20,
  parameter int  NODES   = 1024,
  parameter int  PIX_W   = 16,
  parameter int  TAB_W   = 16,
  parameter int  SUM_W   = 18,
  parameter int  CORR_SH = 8,
  localparam int NAW     = $clog2(NODES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tab_we,
  input  logic [2:0]       tab_sel,
  input  logic [NAW-1:0]   tab_addr,
  input  logic [TAB_W-1:0] tab_wdata,
  input  logic             start_i,
  input  logic             pix_vld,
  input  logic [PIX_W-1:0] pix_dat,
  output logic             done_o,
  output logic [NAW-1:0]   phase_o
);
  import phs_pkg::*;

  localparam int PAW = $clog2(NPIX);
  localparam int F_W = SUM_W + TAB_W + 2;

  st_e               state_q;
  pass_e             pass_q;
  logic [PAW-1:0]    idx_q;
  logic [NAW-1:0]    lo_q, step_q, nd_addr_q;
  logic [F_W-1:0]    mag_lo_q;
  logic [TAB_W-1:0]  pt_q [2];
  logic [TAB_W-1:0]  nt_q [3];
  logic signed [SUM_W-1:0] sum_s, sum_c;
  logic signed [F_W-1:0]   f_val;
  logic [F_W-1:0]    f_mag;
  logic [NAW-1:0]    bis_lo, half;
  logic              take, clr;

  // per-pixel tables: sine (code 0) and cosine (code 1)
  for (genvar g = 0; g < 2; g++) begin : g_ptab
    phs_ram #(.DEPTH(NPIX), .W(TAB_W), .AW(PAW)) u_ram (
      .clk (clk),
      .we  (tab_we && (tab_sel == 3'(g)) && (tab_addr < NAW'(NPIX))),
      .wa  (tab_addr[PAW-1:0]),
      .wd  (tab_wdata),
      .ra  (idx_q),
      .rd  (pt_q[g])
    );
  end

  // per-node tables: sine (2), cosine (3), correction (4)
  for (genvar g = 0; g < 3; g++) begin : g_ntab
    phs_ram #(.DEPTH(NODES), .W(TAB_W), .AW(NAW)) u_ram (
      .clk (clk),
      .we  (tab_we && (tab_sel == 3'(g + 2))),
      .wa  (tab_addr),
      .wd  (tab_wdata),
      .ra  (nd_addr_q),
      .rd  (nt_q[g])
    );
  end

  assign take = (state_q == S_ACC) && pix_vld;
  assign clr  = (state_q == S_IDLE) && start_i;

  phs_corr #(.NPIX(NPIX), .PIX_W(PIX_W), .TAB_W(TAB_W), .SUM_W(SUM_W)) u_corr (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .take  (take),
    .pix   (pix_dat),
    .t_sin (pt_q[0]),
    .t_cos (pt_q[1]),
    .sum_s (sum_s),
    .sum_c (sum_c)
  );

  phs_obj #(.SUM_W(SUM_W), .TAB_W(TAB_W), .CORR_SH(CORR_SH), .F_W(F_W)) u_obj (
    .clk   (clk),
    .sum_s (sum_s),
    .sum_c (sum_c),
    .n_sin (nt_q[0]),
    .n_cos (nt_q[1]),
    .n_cor (nt_q[2]),
    .f     (f_val)
  );

  assign f_mag  = f_val[F_W-1] ? F_W'(-f_val) : F_W'(f_val);
  assign bis_lo = (f_val > 0) ? nd_addr_q : lo_q;
  assign half   = step_q >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      pass_q    <= P_BIS;
      idx_q     <= '0;
      lo_q      <= '0;
      step_q    <= '0;
      nd_addr_q <= '0;
      mag_lo_q  <= '0;
      done_o    <= 1'b0;
      phase_o   <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          idx_q   <= '0;
          state_q <= S_ACC;
        end
        S_ACC: if (pix_vld) begin
          if (idx_q == PAW'(NPIX - 1)) begin
            idx_q   <= '0;
            state_q <= S_FLUSH;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_FLUSH: begin
          lo_q      <= '0;
          step_q    <= NAW'(NODES / 2);
          nd_addr_q <= NAW'(NODES / 2);
          pass_q    <= P_BIS;
          state_q   <= S_RD;
        end
        S_RD:  state_q <= S_MUL;
        S_MUL: state_q <= S_EVAL;
        S_EVAL: begin
          state_q <= S_RD;
          case (pass_q)
            P_BIS: begin
              lo_q   <= bis_lo;
              step_q <= half;
              if (step_q == NAW'(1)) begin
                nd_addr_q <= bis_lo;
                pass_q    <= P_LO;
              end else begin
                nd_addr_q <= bis_lo + half;
              end
            end
            P_LO: begin
              mag_lo_q  <= f_mag;
              nd_addr_q <= lo_q + 1'b1;
              pass_q    <= P_HI;
            end
            default: begin
              phase_o <= (f_mag < mag_lo_q) ? nd_addr_q : lo_q;
              done_o  <= 1'b1;
              pass_q  <= P_BIS;
              state_q <= S_IDLE;
            end
          endcase
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(phase_o));

  // R6
  step_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step_q));

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && state_q != S_IDLE && state_q != S_ACC) |=> state_q != S_ACC);

  // R6
  probe_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_EVAL && pass_q == P_BIS) |-> (nd_addr_q == lo_q + step_q));
endmodule

// File: tb/sim_phase_bisect_est.sv
module sim_phase_bisect_est;
  localparam int  CLK_P   = 10;
  localparam int  NPIX    = 20;
  localparam int  NODES   = 1024;
  localparam int  PIX_W   = 16;
  localparam int  TAB_W   = 16;
  localparam int  SUM_W   = 18;
  localparam int  CORR_SH = 8;
  localparam int  NAW     = $clog2(NODES);
  localparam int  SHR     = PIX_W + TAB_W + $clog2(NPIX) - SUM_W;
  localparam int  LAT     = 3 * NAW + 7;
  localparam real PI      = 3.14159265358979;
  localparam real FREQ    = 0.2;

  logic clk = 0, rst = 1;
  logic tab_we = 0;
  logic [2:0] tab_sel = 0;
  logic [NAW-1:0] tab_addr = 0;
  logic [TAB_W-1:0] tab_wdata = 0;
  logic start_i = 0, pix_vld = 0;
  logic [PIX_W-1:0] pix_dat = 0;
  logic done_o;
  logic [NAW-1:0] phase_o;

  int n_chk = 0, n_err = 0;
  int b_psin [NPIX], b_pcos [NPIX], b_pix [NPIX];
  int b_nsin [NODES], b_ncos [NODES], b_ncor [NODES];

  always #(CLK_P / 2) clk = ~clk;

  phase_bisect_est #(.NPIX(NPIX), .NODES(NODES), .PIX_W(PIX_W), .TAB_W(TAB_W),
                     .SUM_W(SUM_W), .CORR_SH(CORR_SH)) u0 (
    .clk(clk), .rst(rst), .tab_we(tab_we), .tab_sel(tab_sel), .tab_addr(tab_addr),
    .tab_wdata(tab_wdata), .start_i(start_i), .pix_vld(pix_vld), .pix_dat(pix_dat),
    .done_o(done_o), .phase_o(phase_o));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int addr, input int data);
    @(negedge clk);
    tab_we = 1; tab_sel = 3'(sel); tab_addr = NAW'(addr); tab_wdata = TAB_W'(data);
  endtask

  task automatic load_all();
    for (int i = 0; i < NPIX; i++) begin
      wr(0, i, b_psin[i]);
      wr(1, i, b_pcos[i]);
    end
    for (int k = 0; k < NODES; k++) begin
      wr(2, k, b_nsin[k]);
      wr(3, k, b_ncos[k]);
      wr(4, k, b_ncor[k]);
    end
    @(negedge clk);
    tab_we = 0;
  endtask

  function automatic longint fval(input int k, input longint ss, input longint sc);
    return (longint'(b_ncor[k]) <<< CORR_SH) - longint'(b_nsin[k]) * sc
           - longint'(b_ncos[k]) * ss;
  endfunction

  function automatic longint labs(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  // bench model of R4..R7
  function automatic int model();
    longint as_ = 0, ac = 0, ss, sc;
    int lo = 0, step = NODES / 2, hi;
    for (int i = 0; i < NPIX; i++) begin
      as_ += longint'(b_pix[i]) * b_psin[i];
      ac  += longint'(b_pix[i]) * b_pcos[i];
    end
    ss = as_ >>> SHR;
    sc = ac >>> SHR;
    while (step > 0) begin
      if (fval(lo + step, ss, sc) > 0) lo = lo + step;
      step = step / 2;
    end
    hi = (lo + 1) % NODES;
    return (labs(fval(hi, ss, sc)) < labs(fval(lo, ss, sc))) ? hi : lo;
  endfunction

  task automatic run(input bit gaps, input bit junk, input bit busy,
                     output int ph, output int lat, output int ndone);
    ph = -1; lat = -1; ndone = 0;
    if (junk) begin
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        pix_vld = 1; pix_dat = PIX_W'($urandom);
      end
      @(negedge clk);
      pix_vld = 0;
    end
    @(negedge clk);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    for (int i = 0; i < NPIX; i++) begin
      if (gaps) begin
        pix_vld = 0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
      end
      pix_vld = 1; pix_dat = PIX_W'(b_pix[i]);
      @(negedge clk);
    end
    pix_vld = 0;
    for (int k = 1; k <= LAT + 20; k++) begin
      if (busy && k == 5) begin start_i = 1; pix_vld = 1; pix_dat = PIX_W'($urandom); end
      if (busy && k == 6) start_i = 0;
      if (busy && k == 9) pix_vld = 0;
      @(negedge clk);
      if (done_o) begin
        ndone++;
        if (lat < 0) begin lat = k; ph = int'(phase_o); end
      end
    end
  endtask

  task automatic clean_case(input real th, input bit gaps, input string tag);
    int ph, lat, nd, exp;
    real amp, tn, d;
    amp = 6000.0 + real'($urandom_range(0, 8000));
    for (int i = 0; i < NPIX; i++)
      b_pix[i] = int'(amp * $cos(2.0 * PI * FREQ * i + th));
    exp = model();
    run(gaps, 0, 0, ph, lat, nd);
    tn = (th + PI) * NODES / (2.0 * PI);
    d = (real'(ph) > tn) ? real'(ph) - tn : tn - real'(ph);
    if (d > NODES / 2.0) d = NODES - d;
    chk(d <= 1.0, {"R9 ", tag}, ph, int'(tn));
    chk(ph == exp, "R6 R7 clean model", ph, exp);
    chk(lat == LAT && nd == 1, "R8 latency", lat, LAT);
  endtask

  initial begin
    int ph, lat, nd, exp, keep;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(done_o == 0, "R1 done in reset", done_o, 0);
    chk(phase_o == 0, "R1 phase in reset", phase_o, 0);
    rst = 0;
    @(negedge clk);
    chk(done_o == 0 && phase_o == 0, "R1 after reset", phase_o, 0);

    // clean cosine tables (R2 loading, R9 accuracy)
    for (int i = 0; i < NPIX; i++) begin
      b_psin[i] = int'(16384.0 * $sin(2.0 * PI * FREQ * i));
      b_pcos[i] = int'(16384.0 * $cos(2.0 * PI * FREQ * i));
    end
    for (int k = 0; k < NODES; k++) begin
      b_nsin[k] = int'(16384.0 * $sin(-PI + 2.0 * PI * k / NODES));
      b_ncos[k] = int'(16384.0 * $cos(-PI + 2.0 * PI * k / NODES));
      b_ncor[k] = 0;
    end
    load_all();
    clean_case(-PI, 0, "phase -pi");
    clean_case(-PI + 0.003, 0, "near -pi");
    clean_case(0.0, 0, "phase 0");
    clean_case(1.0, 1, "phase 1.0 gaps");
    clean_case(3.1, 0, "phase 3.1");
    clean_case(PI - 0.001, 0, "seam");
    clean_case(-2.5, 1, "phase -2.5");
    for (int t = 0; t < 8; t++)
      clean_case(-PI + 2.0 * PI * real'($urandom_range(0, 9999)) / 10000.0, t[0], "random");

    // R8 hold between strobes
    keep = int'(phase_o);
    repeat (20) @(negedge clk);
    chk(int'(phase_o) == keep, "R8 hold", phase_o, keep);

    // random full-range tables: exact model (R2 R4 R5 R6 R7)
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < NPIX; i++) begin
        b_psin[i] = $signed(16'($urandom));
        b_pcos[i] = $signed(16'($urandom));
      end
      for (int k = 0; k < NODES; k++) begin
        b_nsin[k] = $signed(16'($urandom));
        b_ncos[k] = $signed(16'($urandom));
        b_ncor[k] = $signed(16'($urandom));
      end
      load_all();
      // R2: write beyond the pixel table is dropped (would alias entry 4)
      wr(0, 36, 12345);
      @(negedge clk);
      tab_we = 0;
      for (int t = 0; t < 6; t++) begin
        for (int i = 0; i < NPIX; i++) b_pix[i] = $signed(16'($urandom));
        exp = model();
        run(t[0], 0, 0, ph, lat, nd);
        chk(ph == exp, "R4 R5 R6 R7 R2 random tables", ph, exp);
        chk(lat == LAT, "R8 latency random", lat, LAT);
      end
    end

    // R3: idle pixels and start during search are ignored
    for (int i = 0; i < NPIX; i++) b_pix[i] = $signed(16'($urandom));
    exp = model();
    run(0, 1, 1, ph, lat, nd);
    chk(ph == exp, "R3 ignored stimulus result", ph, exp);
    chk(nd == 1, "R3 single strobe", nd, 1);
    for (int i = 0; i < NPIX; i++) b_pix[i] = $signed(16'($urandom));
    exp = model();
    run(1, 0, 0, ph, lat, nd);
    chk(ph == exp && lat == LAT, "R3 next profile", ph, exp);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule